// File: doc/BRIEF.md
# Threshold-Filtered Capacitor-ID Histogrammer

This block builds one histogram for every pairing of input channel and capacitor ID from ADC words that arrive once per bunch-crossing clock. Every word holds a capacitor ID, a 2-bit exponent and a 5-bit mantissa. The mantissa picks one of 32 bins. With six channels and four capacitor IDs there are 24 histograms. Each bin is a saturating counter.

A small control word sets how samples are counted. In the default mode only samples with a zero exponent are counted. The mantissa-only bit counts every sample at its mantissa bin, whatever its exponent. The pulse-filter bit counts a sample only when it is the centre of three consecutive valid samples on its channel. The two neighbours must lie under a global low (pedestal) threshold, and the centre must lie above a global high (signal) threshold. Both thresholds apply to every histogram at once.

Software reads any bin through a registered address/data port. A clear strobe zeroes every bin over a fixed sweep. The same sweep also runs after reset. A busy output is high during the sweep, and samples presented while it is high are discarded.

Top module: `pulse_hist`

## Requirements
- R1: After reset is released, `busy` stays high for exactly 128 clock cycles and then falls. Once it has fallen, every bin reads 0.
- R2: With `csr` = 0, a valid sample with exponent 0, capacitor ID c and mantissa m on channel k adds one to histogram k*4+c, bin m. A sample with a nonzero exponent is not counted. The input word is laid out as capacitor ID in bits [8:7], exponent in [6:5] and mantissa in [4:0]. Channel k occupies `in_data[k*9 +: 9]`.
- R3: With `csr[2]` = 1 (mantissa only), a valid sample is counted at its mantissa bin whatever its exponent.
- R4: With `csr[0]` = 1 (pulse filter), a sample is counted only if three conditions hold. It must have valid samples on the same channel in the clock cycles just before and just after it. Both of those neighbours must have a code below `thr_lo`. Its own code must be above `thr_hi`. The code of a sample is {exponent, mantissa}, which is 7 bits wide. The sample's own capacitor ID and mantissa pick the bin.
- R5: The filter comparisons are strict. A neighbour whose code equals `thr_lo` blocks the count. A centre whose code equals `thr_hi` blocks the count. An isolated sample that has no valid neighbours is not counted.
- R6: A bin counter that is at its maximum value (2^CW-1) stays there on further hits and does not wrap.
- R7: Bin 31 is counted correctly for the last capacitor ID of the last channel (histogram 23). Its neighbouring histogram and its neighbouring bin are left untouched.
- R8: When `csr[1]` is high for one cycle while idle, `busy` is high for the next 128 cycles. Afterwards every bin reads 0. Samples presented while `busy` is high are never counted.
- R9: `rd_addr` = histogram*32 + bin. `rd_data` shows the bin selected in the previous cycle. A histogram index of 24 or more reads 0.
- R10: A sample on one channel changes no histogram that belongs to another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | NCH | Per-channel sample valid |
| in_data | input | NCH*9 | Packed per-channel sample words |
| csr | input | 3 | Bit 0: filter enable; bit 1: clear strobe; bit 2: mantissa only |
| thr_lo | input | 7 | Pedestal threshold applied to the neighbours |
| thr_hi | input | 7 | Signal threshold applied to the centre |
| busy | output | 1 | Clear sweep in progress |
| rd_addr | input | 10 | Histogram index [9:5], bin index [4:0] |
| rd_data | output | CW | Registered bin count |

## Verification
The bench builds the block with NCH = 6, which gives the full set of 24 histograms. This lets it check bin 31 of the last histogram, and the out-of-range read just past it, at the real edge of the address space. It sets CW = 8, so a bin reaches saturation after 255 hits. A few hundred samples are therefore enough to show that the counter holds at its maximum instead of wrapping.

// File: rtl/pulse_hist_pkg.sv
// Shared sample layout and helpers for the histogrammer.
// Assumes a 9-bit word: capacitor ID in the top bits, then exponent, then mantissa.
package pulse_hist_pkg;
    localparam int MANT_W   = 5;
    localparam int EXP_W    = 2;
    localparam int CAP_W    = 2;
    localparam int SAMPLE_W = MANT_W + EXP_W + CAP_W;
    localparam int CODE_W   = MANT_W + EXP_W;

    typedef struct packed {
        logic [CAP_W-1:0]  cap;
        logic [EXP_W-1:0]  expo;
        logic [MANT_W-1:0] mant;
    } sample_t;

    // Amplitude code used for the threshold comparisons.
    function automatic logic [CODE_W-1:0] amp_code(sample_t s);
        return {s.expo, s.mant};
    endfunction
endpackage

// File: rtl/pulse_hist_qual.sv
// Per-channel qualifier: three-stage sample pipeline plus the low/high/low pulse filter.
// The pipeline shifts on every clock, so the filter's neighbours are the adjacent clock cycles.
// The hit for a centre sample is raised two cycles after that sample is presented.
// Assumes the thresholds are held stable while samples are flowing.
module pulse_hist_qual
    import pulse_hist_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  sample_t             in_word,
    input  logic                busy,
    input  logic                filt_en,
    input  logic                mant_only,
    input  logic [CODE_W-1:0]   thr_lo,
    input  logic [CODE_W-1:0]   thr_hi,
    output logic                hit,
    output logic [CAP_W-1:0]    hit_cap,
    output logic [MANT_W-1:0]   hit_bin
);
    sample_t    s_new, s_mid, s_old;
    logic [2:0] vld;
    logic       exp_ok, shape_ok;

    // Shift samples and their valid bits; samples arriving during a clear are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            vld <= {vld[1:0], in_vld & ~busy};
        end
        s_new <= in_word;
        s_mid <= s_new;
        s_old <= s_mid;
    end

    // Decide whether the centre stage is binned.
    always_comb begin
        exp_ok   = mant_only || (s_mid.expo == '0);
        shape_ok = vld[0] && vld[2]
                && (amp_code(s_old) < thr_lo)
                && (amp_code(s_mid) > thr_hi)
                && (amp_code(s_new) < thr_lo);
        hit      = vld[1] && exp_ok && (!filt_en || shape_ok) && !busy;
        hit_cap  = s_mid.cap;
        hit_bin  = s_mid.mant;
    end

    AST_FILT_CENTRE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && filt_en) |-> (amp_code($past(in_word, 2)) > thr_hi)); // R4
    AST_FILT_NEIGHBOURS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && filt_en) |-> ((amp_code($past(in_word, 1)) < thr_lo)
                           && (amp_code($past(in_word, 3)) < thr_lo))); // R5
endmodule

// File: rtl/pulse_hist_bank.sv
// Bin storage for one channel: one histogram per capacitor ID, with saturating counters.
// A clear write takes priority over a hit. The read port is combinational.
module pulse_hist_bank
    import pulse_hist_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit,
    input  logic [CAP_W-1:0]    hit_cap,
    input  logic [MANT_W-1:0]   hit_bin,
    input  logic                clr,
    input  logic [CAP_W+MANT_W-1:0] clr_idx,
    input  logic [CAP_W+MANT_W-1:0] rd_idx,
    output logic [CW-1:0]       rd_val
);
    localparam int IW = CAP_W + MANT_W;
    localparam int NE = 1 << IW;
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] cnt [NE];
    logic [IW-1:0] w_idx;

    assign w_idx  = {hit_cap, hit_bin};
    assign rd_val = cnt[rd_idx];

    // Zero a swept entry, or add one to the hit entry unless it is already full.
    always_ff @(posedge clk) begin
        if (clr) begin
            cnt[clr_idx] <= '0;
        end else if (hit && (cnt[w_idx] != CMAX)) begin
            cnt[w_idx] <= cnt[w_idx] + 1'b1;
        end
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt[$past(clr_idx)] == '0)); // R8
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clr) |=> (cnt[$past(w_idx)] != '0)); // R6
endmodule

// File: rtl/pulse_hist.sv
// Top of the histogrammer: per-channel qualifiers and banks, the clear sweep, and the read mux.
// Assumes NCH >= 2. The sweep visits every entry of all banks in parallel, so it lasts NCAP*NB cycles.
// The sweep also runs after reset, so the bins need no reset of their own.
module pulse_hist
    import pulse_hist_pkg::*;
#(
    parameter int NCH = 6,
    parameter int CW  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCH-1:0]                in_vld,
    input  logic [NCH*SAMPLE_W-1:0]       in_data,
    input  logic [2:0]                    csr,
    input  logic [CODE_W-1:0]             thr_lo,
    input  logic [CODE_W-1:0]             thr_hi,
    output logic                          busy,
    input  logic [$clog2(NCH<<CAP_W)+MANT_W-1:0] rd_addr,
    output logic [CW-1:0]                 rd_data
);
    localparam int NCAP = 1 << CAP_W;
    localparam int NB   = 1 << MANT_W;
    localparam int NH   = NCH * NCAP;
    localparam int HW   = $clog2(NH);
    localparam int AW   = HW + MANT_W;
    localparam int CHW  = HW - CAP_W;
    localparam int IW   = CAP_W + MANT_W;
    localparam logic [IW-1:0] LAST = IW'(NCAP * NB - 1);

    logic [IW-1:0]     clr_cnt;
    logic [NCH-1:0]    hit;
    logic [CAP_W-1:0]  hit_cap [NCH];
    logic [MANT_W-1:0] hit_bin [NCH];
    logic [CW-1:0]     bank_val [NCH];
    logic [HW-1:0]     rd_hist;
    logic [CHW-1:0]    rd_chan;
    logic [IW-1:0]     rd_idx;
    logic [CW-1:0]     rd_sel;

    // Clear sweep: start on reset or on the strobe, then step through every entry once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b1;
            clr_cnt <= '0;
        end else if (busy) begin
            busy    <= (clr_cnt != LAST);
            clr_cnt <= (clr_cnt == LAST) ? '0 : clr_cnt + 1'b1;
        end else if (csr[1]) begin
            busy    <= 1'b1;
            clr_cnt <= '0;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_chan
            pulse_hist_qual u_qual (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_vld    (in_vld[g]),
                .in_word   (sample_t'(in_data[g*SAMPLE_W +: SAMPLE_W])),
                .busy      (busy),
                .filt_en   (csr[0]),
                .mant_only (csr[2]),
                .thr_lo    (thr_lo),
                .thr_hi    (thr_hi),
                .hit       (hit[g]),
                .hit_cap   (hit_cap[g]),
                .hit_bin   (hit_bin[g])
            );
            pulse_hist_bank #(.CW(CW)) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .hit     (hit[g]),
                .hit_cap (hit_cap[g]),
                .hit_bin (hit_bin[g]),
                .clr     (busy),
                .clr_idx (clr_cnt),
                .rd_idx  (rd_idx),
                .rd_val  (bank_val[g])
            );
        end
    endgenerate

    // Split the read address and pick the addressed channel's bank.
    always_comb begin
        rd_hist = rd_addr[AW-1:MANT_W];
        rd_chan = rd_hist[HW-1:CAP_W];
        rd_idx  = {rd_hist[CAP_W-1:0], rd_addr[MANT_W-1:0]};
        rd_sel  = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_chan == CHW'(i)) rd_sel = bank_val[i];
        end
    end

    // Register the read result; histogram indices past the end read zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= (32'(rd_hist) < NH) ? rd_sel : '0;
        end
    end

    AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rd_addr[AW-1:MANT_W]) >= NH) |=> (rd_data == '0)); // R9
    AST_SWEEP_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (clr_cnt == '0)); // R8
    AST_SWEEP_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(clr_cnt) == LAST)); // R1
endmodule

// File: tb/pulse_hist_tb.sv
`timescale 1ns/1ps
module pulse_hist_tb;
    localparam int NCH = 6;
    localparam int CW  = 8;
    localparam int AW  = 10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NCH-1:0]    in_vld;
    logic [NCH*9-1:0]  in_data;
    logic [2:0]        csr;
    logic [6:0]        thr_lo, thr_hi;
    logic              busy;
    logic [AW-1:0]     rd_addr;
    logic [CW-1:0]     rd_data;

    int n_chk  = 0;
    int n_fail = 0;

    pulse_hist #(.NCH(NCH), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
        .csr(csr), .thr_lo(thr_lo), .thr_hi(thr_hi), .busy(busy),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    function automatic logic [8:0] mk(int cap, int ex, int mant);
        return {cap[1:0], ex[1:0], mant[4:0]};
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(int hist, int bin, output int val);
        rd_addr = AW'(hist * 32 + bin);
        @(negedge clk);
        val = int'(rd_data);
    endtask

    task automatic put(int ch, logic [8:0] w);
        in_vld = '0;
        in_vld[ch] = 1'b1;
        in_data[ch*9 +: 9] = w;
        @(negedge clk);
        in_vld = '0;
    endtask

    task automatic seq3(int ch, logic [8:0] a, logic [8:0] b, logic [8:0] c);
        in_vld = '0;
        in_vld[ch] = 1'b1;
        in_data[ch*9 +: 9] = a; @(negedge clk);
        in_data[ch*9 +: 9] = b; @(negedge clk);
        in_data[ch*9 +: 9] = c; @(negedge clk);
        in_vld = '0;
        idle(4);
    endtask

    task automatic t_reset;
        int n, v;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R1 busy cycles after reset", n, 128);
        rd(0, 0, v);   check("R1 bin 0/0 after reset", v, 0);
        rd(23, 31, v); check("R1 bin 23/31 after reset", v, 0);
    endtask

    task automatic t_basic;
        int v;
        csr = 3'b000;
        put(0, mk(1, 0, 5));
        put(3, mk(2, 1, 7));
        idle(4);
        rd(1, 5, v);  check("R2 ch0 cap1 bin5", v, 1);
        rd(14, 7, v); check("R2 nonzero exponent ignored", v, 0);
        rd(5, 5, v);  check("R10 ch1 cap1 bin5 untouched", v, 0);
    endtask

    task automatic t_mant;
        int v;
        csr = 3'b100;
        put(3, mk(2, 1, 7));
        idle(4);
        rd(14, 7, v); check("R3 mantissa only counts exp1", v, 1);
        csr = 3'b000;
    endtask

    task automatic t_filter;
        int v;
        csr = 3'b001; thr_lo = 7'd4; thr_hi = 7'd20;
        seq3(2, mk(0, 0, 2), mk(3, 0, 25), mk(0, 0, 3));
        rd(11, 25, v); check("R4 filtered pulse counted", v, 1);
        rd(8, 2, v);   check("R4 low neighbour not binned", v, 0);
        rd(8, 3, v);   check("R4 low neighbour not binned", v, 0);
        seq3(2, mk(0, 0, 4), mk(3, 0, 25), mk(0, 0, 1));
        rd(11, 25, v); check("R5 neighbour equal to low threshold", v, 1);
        seq3(2, mk(0, 0, 1), mk(3, 0, 20), mk(0, 0, 1));
        rd(11, 20, v); check("R5 centre equal to high threshold", v, 0);
        put(2, mk(3, 0, 25));
        idle(4);
        rd(11, 25, v); check("R5 isolated sample", v, 1);
        csr = 3'b000;
    endtask

    task automatic t_bin31;
        int v;
        in_vld = '0; in_vld[5] = 1'b1;
        in_data[5*9 +: 9] = mk(3, 0, 31);
        idle(3);
        in_vld = '0;
        idle(4);
        rd(23, 31, v); check("R7 hist 23 bin 31", v, 3);
        rd(22, 31, v); check("R7 hist 22 bin 31", v, 0);
        rd(23, 30, v); check("R7 hist 23 bin 30", v, 0);
    endtask

    task automatic t_range;
        int v;
        rd(24, 0, v);  check("R9 hist 24 reads zero", v, 0);
        rd(31, 31, v); check("R9 hist 31 reads zero", v, 0);
    endtask

    task automatic t_sat;
        int v;
        in_vld = '0; in_vld[4] = 1'b1;
        in_data[4*9 +: 9] = mk(0, 0, 9);
        idle(300);
        in_vld = '0;
        idle(4);
        rd(16, 9, v); check("R6 counter saturates", v, 255);
    endtask

    task automatic t_clear;
        int n, v;
        csr = 3'b010;
        @(negedge clk);
        csr = 3'b000;
        in_vld = '0; in_vld[0] = 1'b1;
        in_data[0*9 +: 9] = mk(1, 0, 5);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        in_vld = '0;
        check("R8 busy cycles on clear", n, 128);
        idle(4);
        rd(1, 5, v);  check("R8 bin cleared and busy samples dropped", v, 0);
        rd(16, 9, v); check("R8 saturated bin cleared", v, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_vld = '0; in_data = '0; csr = 3'b000;
        thr_lo = 7'd0; thr_hi = 7'd0; rd_addr = '0;
        idle(3);
        check("R1 busy during reset", int'(busy), 1);
        rst_n = 1'b1;
        t_reset;
        t_basic;
        t_mant;
        t_filter;
        t_bin31;
        t_range;
        t_sat;
        t_clear;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule